// File: doc/BRIEF.md
# Reset-Window Guarded Configuration Bank

This block holds six small system configuration registers. Their bits do not all follow the same write rule. Some bits take writes only during a short span of clock cycles after reset is released. Some take a single write. Protection bits can always be raised but can be lowered only inside that span. One whole register takes a single write, and only inside the span. A special-mode flag removes the time limit from every span-limited bit. It does not remove the single-write limits on individual bits.

While reset is held, the block samples two mode-select pins on every clock and decodes them into three mode outputs. The value held in the last reset cycle is kept until the next reset. A simple synchronous bus reads and writes the registers: address, write data, write strobe, and combinational read data. Every register value is also available on its own output port. A write is judged bit by bit. Permitted bits take the new value and forbidden bits keep their old value.

Top module: `cfgwin_bank`

## Requirements
- R1: While `rst` is high, the registers take these reset values: timer mask (address 0) 0x00, block protect (address 1) 0xFF, options-2 (address 2) 0x00, options (address 3) 0x10, priority/misc (address 4) 0x00, map (address 5) 0x01. All single-write locks clear and the cycle counter returns to 0.
- R2: The counter advances once per clock after `rst` falls and saturates at WINDOW. A write is inside the window when the counter is below WINDOW on the edge that takes the strobe. The first WINDOW edges after release are therefore inside, and the window never reopens before the next reset.
- R3: When the latched special flag is 1, every window-limited bit accepts a write at any time.
- R4: At address 0, bits 1 and 0 are window-limited. Bits 7 to 2 always accept writes.
- R5: At address 3, bits 5, 4, 2, 1 and 0 are window-limited. Bits 7, 6 and 3 always accept writes.
- R6: At address 1, a bit written with 1 becomes 1 at any time. A bit written with 0 becomes 0 only inside the window or in special mode; otherwise it keeps its value.
- R7: At address 2, bit 5 takes only the first write after reset, in any window state and in any mode. The other bits always accept writes.
- R8: At address 4, bit 4 takes only the first write after reset. The other bits always accept writes.
- R9: In normal modes, address 5 takes exactly one write, and only inside the window. In special mode it takes every write.
- R10: The pins sampled during reset give the outputs (boot, special, expanded): b=1,a=0 gives 0,0,0; b=1,a=1 gives 0,0,1; b=0,a=0 gives 1,1,0; b=0,a=1 gives 0,1,1. Pin changes after release have no effect.
- R11: Reads are always permitted. Unused addresses 6 and 7 read 0 and ignore writes. The permitted bits of a partly forbidden write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are sampled while high |
| mode_pin_a | input | 1 | Mode select pin a |
| mode_pin_b | input | 1 | Mode select pin b |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tmask_q | output | 8 | Timer mask register |
| prot_q | output | 8 | Block protect register |
| opt2_q | output | 8 | Options-2 register |
| opt_q | output | 8 | Options register |
| prio_q | output | 8 | Priority/misc register |
| map_q | output | 8 | Map register |
| boot_rom_en | output | 1 | Latched boot mode bit |
| special_mode | output | 1 | Latched special-mode flag |
| expanded_bus | output | 1 | Latched expanded-bus bit |

## Verification
The bench builds the block with WINDOW=8 and ADDR_W=3. With this window, every mode can reach both sides of the window boundary within a few cycles. The sweep also runs past the point where a 4-bit counter would wrap, so a counter that failed to saturate would reopen the window and show up. For each of the four pin combinations, the bench resets the block and makes writes inside the window. It then sweeps a set of data patterns over all eight addresses and compares every read against an arithmetic model of the per-bit rules.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int DATA_W = 8;
    localparam int NREG   = 6;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic boot;
        logic special;
        logic expanded;
    } mode_t;

    // register indices (bus addresses)
    localparam int IDX_TMASK = 0;
    localparam int IDX_PROT  = 1;
    localparam int IDX_OPT2  = 2;
    localparam int IDX_OPT   = 3;
    localparam int IDX_PRIO  = 4;
    localparam int IDX_MAP   = 5;

    function automatic byte_t reset_val(input int idx);
        case (idx)
            IDX_PROT: return 8'hFF;
            IDX_OPT:  return 8'h10;
            IDX_MAP:  return 8'h01;
            default:  return 8'h00;
        endcase
    endfunction

    // bits that only accept writes inside the window (or in special mode)
    function automatic byte_t win_mask(input int idx);
        case (idx)
            IDX_TMASK: return 8'h03;
            IDX_OPT:   return 8'h37;
            default:   return 8'h00;
        endcase
    endfunction

    // bits that accept a single write after reset
    function automatic byte_t once_mask(input int idx);
        case (idx)
            IDX_OPT2: return 8'h20;
            IDX_PRIO: return 8'h10;
            default:  return 8'h00;
        endcase
    endfunction

    // bits that may be set at any time but cleared only when open
    function automatic byte_t setonly_mask(input int idx);
        return (idx == IDX_PROT) ? 8'hFF : 8'h00;
    endfunction

    // whole register single-write, window-only in normal modes
    function automatic bit whole_once(input int idx);
        return idx == IDX_MAP;
    endfunction

    function automatic mode_t decode_mode(input logic pin_b, input logic pin_a);
        mode_t m;
        m.boot     = !pin_b && !pin_a;
        m.special  = !pin_b;
        m.expanded = pin_a;
        return m;
    endfunction

endpackage

// File: rtl/cfgwin_window_ctr.sv
module cfgwin_window_ctr #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst,
    output logic in_window
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign in_window = (cnt < LIMIT);

    // R2: once saturated, the count stays put until reset
    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIMIT) |=> (cnt == LIMIT));

    // R2: the window, once closed, never reopens
    a_r2_no_reopen: assert property (@(posedge clk) disable iff (rst)
        !in_window |=> !in_window);

endmodule

// File: rtl/cfgwin_mode_latch.sv
module cfgwin_mode_latch
    import cfgwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_a,
    input  logic  pin_b,
    output mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= decode_mode(pin_b, pin_a);
    end

    // R10: pins have no influence once reset is released
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode));

    // R10: boot mode is always a special mode
    a_r10_boot_special: assert property (@(posedge clk) disable iff (rst)
        mode.boot |-> mode.special);

endmodule

// File: rtl/cfgwin_reg.sv
module cfgwin_reg
    import cfgwin_pkg::*;
#(
    parameter byte_t RST_VAL  = 8'h00,
    parameter byte_t WIN_M    = 8'h00,
    parameter byte_t ONCE_M   = 8'h00,
    parameter byte_t SETONLY_M = 8'h00,
    parameter bit    WHOLE_ONCE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    input  logic  in_window,
    input  logic  special,
    output byte_t q
);
    logic open_w;
    logic wr_ok;

    assign open_w = in_window || special;

    generate
        if (WHOLE_ONCE) begin : g_whole
            logic used;
            always_ff @(posedge clk) begin
                if (rst)
                    used <= 1'b0;
                else if (wr_en && !special && in_window)
                    used <= 1'b1;
            end
            assign wr_ok = wr_en && (special || (in_window && !used));

            // R9: a used or out-of-window register ignores writes in normal mode
            a_r9_map_hold: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !special && (used || !in_window)) |=> $stable(q));
        end else begin : g_plain
            assign wr_ok = wr_en;
        end
    endgenerate

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic bq;
            assign q[i] = bq;

            if (ONCE_M[i]) begin : g_once
                logic taken;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        bq    <= RST_VAL[i];
                        taken <= 1'b0;
                    end else if (wr_ok && !taken) begin
                        bq    <= wdata[i];
                        taken <= 1'b1;
                    end
                end
                // R7 / R8: a taken single-write bit never changes again
                a_r7_once_hold: assert property (@(posedge clk) disable iff (rst)
                    taken |=> $stable(bq));
            end else if (SETONLY_M[i]) begin : g_setonly
                always_ff @(posedge clk) begin
                    if (rst)
                        bq <= RST_VAL[i];
                    else if (wr_ok) begin
                        if (wdata[i])
                            bq <= 1'b1;
                        else if (open_w)
                            bq <= 1'b0;
                    end
                end
                // R6: no clearing outside the window in normal mode
                a_r6_no_clear: assert property (@(posedge clk) disable iff (rst)
                    (wr_ok && !open_w && bq) |=> bq);
            end else if (WIN_M[i]) begin : g_win
                always_ff @(posedge clk) begin
                    if (rst)
                        bq <= RST_VAL[i];
                    else if (wr_ok && open_w)
                        bq <= wdata[i];
                end
                // R2 / R3: window-limited bit is frozen when closed in normal mode
                a_r2_win_hold: assert property (@(posedge clk) disable iff (rst)
                    (!in_window && !special) |=> $stable(bq));
            end else begin : g_free
                always_ff @(posedge clk) begin
                    if (rst)
                        bq <= RST_VAL[i];
                    else if (wr_ok)
                        bq <= wdata[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
    import cfgwin_pkg::*;
#(
    parameter int WINDOW = 64,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pin_a,
    input  logic              mode_pin_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        tmask_q,
    output logic [7:0]        prot_q,
    output logic [7:0]        opt2_q,
    output logic [7:0]        opt_q,
    output logic [7:0]        prio_q,
    output logic [7:0]        map_q,
    output logic              boot_rom_en,
    output logic              special_mode,
    output logic              expanded_bus
);
    logic  in_window;
    mode_t mode;
    byte_t regs [NREG];

    cfgwin_window_ctr #(.WINDOW(WINDOW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .in_window (in_window)
    );

    cfgwin_mode_latch u_mode (
        .clk   (clk),
        .rst   (rst),
        .pin_a (mode_pin_a),
        .pin_b (mode_pin_b),
        .mode  (mode)
    );

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            logic sel;
            assign sel = bus_we && (bus_addr == ADDR_W'(r));
            cfgwin_reg #(
                .RST_VAL   (reset_val(r)),
                .WIN_M     (win_mask(r)),
                .ONCE_M    (once_mask(r)),
                .SETONLY_M (setonly_mask(r)),
                .WHOLE_ONCE(whole_once(r))
            ) u_reg (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (sel),
                .wdata     (bus_wdata),
                .in_window (in_window),
                .special   (mode.special),
                .q         (regs[r])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NREG; r++)
            if (bus_addr == ADDR_W'(r))
                bus_rdata = regs[r];
    end

    assign tmask_q      = regs[IDX_TMASK];
    assign prot_q       = regs[IDX_PROT];
    assign opt2_q       = regs[IDX_OPT2];
    assign opt_q        = regs[IDX_OPT];
    assign prio_q       = regs[IDX_PRIO];
    assign map_q        = regs[IDX_MAP];
    assign boot_rom_en  = mode.boot;
    assign special_mode = mode.special;
    assign expanded_bus = mode.expanded;

    // R11: addresses beyond the bank always read zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(NREG)) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_cfgwin_bank.sv
module tb_cfgwin_bank;
    localparam int WIN = 8;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pa = 1'b0, pb = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          we = 1'b0;
    logic [7:0]    rdata, tmask_q, prot_q, opt2_q, opt_q, prio_q, map_q;
    logic          boot, spec, expd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] m [8];
    bit lk_o2, lk_pr, lk_map;
    bit e_boot, e_spec, e_exp;

    always #5 clk = ~clk;

    cfgwin_bank #(.WINDOW(WIN), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .mode_pin_a(pa), .mode_pin_b(pb),
        .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata),
        .tmask_q(tmask_q), .prot_q(prot_q), .opt2_q(opt2_q), .opt_q(opt_q),
        .prio_q(prio_q), .map_q(map_q),
        .boot_rom_en(boot), .special_mode(spec), .expanded_bus(expd)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic string req_of(input int a);
        case (a)
            0: return "R4";
            1: return "R6";
            2: return "R7";
            3: return "R5";
            4: return "R8";
            5: return "R9";
            default: return "R11";
        endcase
    endfunction

    // model of the per-bit rules from the requirements
    task automatic model_write(input int a, input logic [7:0] d);
        bit win, open;
        win  = cyc < WIN;
        open = win || e_spec;
        case (a)
            0: m[0] = open ? d : ((d & 8'hFC) | (m[0] & 8'h03));
            1: m[1] = open ? d : (m[1] | d);
            2: begin
                m[2] = lk_o2 ? ((d & 8'hDF) | (m[2] & 8'h20)) : d;
                lk_o2 = 1'b1;
            end
            3: m[3] = open ? d : ((d & 8'hC8) | (m[3] & 8'h37));
            4: begin
                m[4] = lk_pr ? ((d & 8'hEF) | (m[4] & 8'h10)) : d;
                lk_pr = 1'b1;
            end
            5: begin
                if (e_spec) m[5] = d;
                else if (win && !lk_map) begin m[5] = d; lk_map = 1'b1; end
            end
            default: ;
        endcase
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(posedge clk);
        model_write(a, d);
        cyc++;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        addr = AW'(a); we = 1'b0;
        #1;
        check(rdata, m[a], tag);
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic b, input logic a_pin);
        @(negedge clk);
        rst = 1'b1; pb = b; pa = a_pin; we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        m[0] = 8'h00; m[1] = 8'hFF; m[2] = 8'h00; m[3] = 8'h10;
        m[4] = 8'h00; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
        lk_o2 = 0; lk_pr = 0; lk_map = 0;
        e_boot = !b && !a_pin; e_spec = !b; e_exp = a_pin;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pats [7];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hAA;
        pats[4] = 8'h0F; pats[5] = 8'hF0; pats[6] = 8'h3C;

        for (int md = 0; md < 4; md++) begin
            do_reset(md[1], md[0]);
            // R1 reset values, observed on the direct outputs before any write
            #1;
            check(tmask_q, 8'h00, "R1 tmask reset");
            check(prot_q,  8'hFF, "R1 prot reset");
            check(opt2_q,  8'h00, "R1 opt2 reset");
            check(opt_q,   8'h10, "R1 opt reset");
            check(prio_q,  8'h00, "R1 prio reset");
            check(map_q,   8'h01, "R1 map reset");
            // R10 mode decode, then pins toggled to show they no longer matter
            check({7'd0, boot}, {7'd0, e_boot}, "R10 boot");
            check({7'd0, spec}, {7'd0, e_spec}, "R10 special");
            check({7'd0, expd}, {7'd0, e_exp},  "R10 expanded");
            pa = ~pa; pb = ~pb;
            // in-window writes (cycles 0..5) covering R2 inside the window
            wr(0, 8'hFF);
            wr(1, 8'h00);
            wr(3, 8'hFF);
            wr(5, 8'h5A);
            wr(2, 8'hFF);
            wr(4, 8'hFF);
            for (int a = 0; a < 6; a++) rd(a, {"R2 in-window ", req_of(a)});
            // sweep well past the window and past any counter wrap (R2 saturation, R3)
            for (int p = 0; p < 7; p++) begin
                for (int a = 0; a < 8; a++) begin
                    wr(a, pats[p]);
                    rd(a, e_spec ? {"R3 ", req_of(a)} : {"R2 ", req_of(a)});
                end
            end
            #1;
            check({7'd0, boot}, {7'd0, e_boot}, "R10 boot held");
            check({7'd0, spec}, {7'd0, e_spec}, "R10 special held");
            check({7'd0, expd}, {7'd0, e_exp},  "R10 expanded held");
            check(prot_q, m[1], "R11 direct prot");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule